// File: doc/BRIEF.md
# Receive descriptor look-ahead controller

This block sits on the receive side of a network interface. Bytes arrive one per cycle at most. Each byte carries a start-of-frame flag and an end-of-frame flag. The block places the bytes into host buffers that a small ring of descriptors describes. The descriptors are held in an internal register array. The host loads and inspects them through a simple write port and a combinational read port.

Each descriptor holds a buffer base address, a buffer length in bytes and a byte count. It also holds four flags: owned-by-controller, start-of-packet, end-of-packet and error. A frame is held back in a receive FIFO until its threshold byte arrives, or until its last byte arrives if that comes first. From then on the bytes flow into the current buffer. When that buffer fills, it is handed back to the host. The block then checks that the next descriptor is available before it continues.

An option input lets a returned start-of-packet descriptor raise the receive interrupt early. The host can then grant later descriptors while the frame is still arriving. A look-ahead read at the threshold byte never fails by itself. Only the final ownership check made at a full buffer can end a frame with a buffer error.

Top module: `rxla_ctrl`

## Requirements
- R1: After reset every descriptor reads back with all fields zero (flags 0, count 0), and `mem_we`, `rx_irq` and `buf_err` are low.
- R2: No buffer write for a frame happens before its THRESH-th byte has arrived, unless its end-of-frame byte arrives first; held bytes stay in the FIFO.
- R3: Once released, a frame's bytes are written in arrival order, at most one per cycle. A buffer is written starting at its base address, and each byte goes to base plus its offset within that buffer.
- R4: When the end-of-frame byte is stored, the current descriptor is returned. Its count is set to the bytes placed in that buffer, its end-of-packet flag is set and its owned flag is cleared. The ring pointer advances and `rx_irq` pulses for one cycle.
- R5: When a buffer fills while the frame continues and the next descriptor is owned, the filled descriptor is returned with count equal to its length and with end-of-packet and error both clear. Filling continues at offset 0 of the next buffer, and `buf_err` stays low.
- R6: Returning a non-final descriptor whose start-of-packet flag is set pulses `rx_irq` only when `early_irq_en` is 1. Other non-final returns raise no interrupt.
- R7: A look-ahead that finds the next descriptor not owned raises no error. A grant that reaches that descriptor before the current buffer fills is honoured.
- R8: If the next descriptor is still not owned when a buffer fills mid-frame, the current descriptor is returned with error set, count equal to its length and owned clear. `rx_irq` and `buf_err` pulse once, and the rest of the frame is discarded without writes.
- R9: A frame that starts while the descriptor under the ring pointer is not owned is discarded entirely, with no writes and no interrupt. `buf_err` pulses once and the ring pointer does not move.
- R10: The ring pointer wraps from descriptor RING-1 to descriptor 0.
- R11: A host write claims its cycle; the controller neither pops the FIFO nor touches any descriptor in that cycle. A host write sets base, length, owned and start-of-packet, and clears the count, end-of-packet and error.
- R12: The read flags are encoded as bit 0 owned, bit 1 start-of-packet, bit 2 end-of-packet and bit 3 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early_irq_en | input | 1 | Interrupt on return of a start-of-packet descriptor |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | Byte is the first of its frame |
| in_eof | input | 1 | Byte is the last of its frame |
| host_we | input | 1 | Host descriptor write strobe |
| host_widx | input | IW | Descriptor index written |
| host_wbase | input | AW | Buffer base address written |
| host_wlen | input | LW | Buffer length written |
| host_wown | input | 1 | Owned flag written |
| host_wstp | input | 1 | Start-of-packet flag written |
| host_ridx | input | IW | Descriptor index read |
| host_rbase | output | AW | Base address of read descriptor |
| host_rlen | output | LW | Length of read descriptor |
| host_rcnt | output | LW | Byte count of read descriptor |
| host_rflags | output | 4 | Flags of read descriptor (R12 encoding) |
| mem_we | output | 1 | Buffer byte write valid |
| mem_addr | output | AW | Buffer byte address |
| mem_data | output | 8 | Buffer byte data |
| rx_irq | output | 1 | Receive interrupt pulse |
| buf_err | output | 1 | Buffer error pulse |

## Verification
The bench builds the block with a ring of four descriptors, a threshold of 16 bytes and 8-bit lengths. With these values a single 40-byte frame crosses the threshold and spans three buffers. The ring wraps within a few frames, and both outcomes of the final ownership check come from frames of a few dozen bytes. Host grants are timed off the early interrupt and the threshold byte, so the look-ahead miss and the later grant can be told apart.

// File: rtl/rxla_ctrl.sv
module rxla_ctrl #(
  parameter int RING   = 8,
  parameter int THRESH = 64,
  parameter int AW     = 16,
  parameter int LW     = 12,
  localparam int IW    = (RING > 1) ? $clog2(RING) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          early_irq_en,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          host_we,
  input  logic [IW-1:0] host_widx,
  input  logic [AW-1:0] host_wbase,
  input  logic [LW-1:0] host_wlen,
  input  logic          host_wown,
  input  logic          host_wstp,
  input  logic [IW-1:0] host_ridx,
  output logic [AW-1:0] host_rbase,
  output logic [LW-1:0] host_rlen,
  output logic [LW-1:0] host_rcnt,
  output logic [3:0]    host_rflags,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          rx_irq,
  output logic          buf_err
);
  localparam int FD = 2 ** $clog2(2 * THRESH);
  localparam int PW = $clog2(FD);
  localparam int CW = $clog2(THRESH + 1);

  typedef enum logic [1:0] {S_WAIT, S_FILL, S_DROP} st_t;

  logic [AW-1:0] d_base [RING];
  logic [LW-1:0] d_len  [RING];
  logic [LW-1:0] d_cnt  [RING];
  logic [RING-1:0] d_own, d_stp, d_enp, d_err;

  logic [9:0]    fq [FD];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   used, rel, pend, add;
  logic [CW-1:0] icnt, n_cnt;
  logic          ihot, cont, hit, trig;

  st_t           st;
  logic [LW-1:0] off, woff;
  logic [IW-1:0] cur, nxt;
  logic          la_own, la_req;
  logic          go, h_sof, h_eof, start, store, miss, wlast, nxt_ok, close, cerr, dropping;
  logic [7:0]    h_data;

  assign cont  = ihot && !in_sof;
  assign n_cnt = in_sof ? CW'(1) : (icnt == CW'(THRESH)) ? icnt : icnt + CW'(1);
  assign hit   = in_valid && !cont && (in_eof || n_cnt == CW'(THRESH));
  assign trig  = in_valid && !cont && n_cnt == CW'(THRESH);
  assign add   = !in_valid ? '0 : cont ? (PW+1)'(1) : hit ? pend + (PW+1)'(1) : '0;

  always_ff @(posedge clk) begin
    if (in_valid) fq[wp] <= {in_eof, in_sof, in_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; used <= '0; rel <= '0;
      pend <= '0; icnt <= '0; ihot <= 1'b0;
    end else begin
      if (in_valid) begin
        wp   <= wp + PW'(1);
        icnt <= n_cnt;
        pend <= (cont || hit) ? '0 : pend + (PW+1)'(1);
        ihot <= hit ? !in_eof : (cont && !in_eof);
      end
      if (go) rp <= rp + PW'(1);
      used <= used + {{PW{1'b0}}, in_valid} - {{PW{1'b0}}, go};
      rel  <= rel + add - {{PW{1'b0}}, go};
    end
  end

  assign {h_eof, h_sof, h_data} = fq[rp];
  assign dropping = st == S_DROP;
  assign go     = rel != '0 && !host_we;
  assign start  = st == S_WAIT && h_sof && d_own[cur];
  assign store  = go && (st == S_FILL || start);
  assign miss   = go && st == S_WAIT && h_sof && !d_own[cur];
  assign woff   = (st == S_FILL) ? off : '0;
  assign wlast  = woff + LW'(1) == d_len[cur];
  assign nxt    = (cur == IW'(RING - 1)) ? '0 : cur + IW'(1);
  assign nxt_ok = la_own || d_own[nxt];
  assign close  = store && (h_eof || wlast);
  assign cerr   = store && !h_eof && wlast && !nxt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RING; i++) begin
        d_base[i] <= '0; d_len[i] <= '0; d_cnt[i] <= '0;
      end
      d_own <= '0; d_stp <= '0; d_enp <= '0; d_err <= '0;
    end else begin
      for (int i = 0; i < RING; i++) begin
        if (host_we && host_widx == IW'(i)) begin
          d_base[i] <= host_wbase;
          d_len[i]  <= host_wlen;
          d_cnt[i]  <= '0;
          d_own[i]  <= host_wown;
          d_stp[i]  <= host_wstp;
          d_enp[i]  <= 1'b0;
          d_err[i]  <= 1'b0;
        end else if (close && cur == IW'(i)) begin
          d_cnt[i]  <= woff + LW'(1);
          d_own[i]  <= 1'b0;
          d_enp[i]  <= h_eof;
          d_err[i]  <= cerr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT; off <= '0; cur <= '0;
      la_own <= 1'b0; la_req <= 1'b0;
      mem_we <= 1'b0; mem_addr <= '0; mem_data <= '0;
      rx_irq <= 1'b0; buf_err <= 1'b0;
    end else begin
      mem_we <= store;
      if (store) begin
        mem_addr <= d_base[cur] + AW'(woff);
        mem_data <= h_data;
      end
      rx_irq  <= close && (h_eof || cerr || (early_irq_en && d_stp[cur]));
      buf_err <= miss || cerr;
      if (close) cur <= nxt;
      la_req <= trig || (la_req && (host_we || close));
      if (close) la_own <= 1'b0;
      else if (la_req && !host_we) la_own <= d_own[nxt];
      if (store) begin
        off <= close ? '0 : woff + LW'(1);
        st  <= !close ? S_FILL : h_eof ? S_WAIT : cerr ? S_DROP : S_FILL;
      end else if (miss) begin
        st <= h_eof ? S_WAIT : S_DROP;
      end else if (go && dropping && h_eof) begin
        st <= S_WAIT;
      end
    end
  end

  assign host_rbase  = d_base[host_ridx];
  assign host_rlen   = d_len[host_ridx];
  assign host_rcnt   = d_cnt[host_ridx];
  assign host_rflags = {d_err[host_ridx], d_enp[host_ridx], d_stp[host_ridx], d_own[host_ridx]};
endmodule

module rxla_ctrl_chk #(
  parameter int RING = 8,
  parameter int IW   = 3,
  parameter int PW   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic          pop,
  input logic          store,
  input logic          miss,
  input logic          adv,
  input logic [IW-1:0] cur,
  input logic [PW:0]   rel,
  input logic [PW:0]   used,
  input logic          dropping,
  input logic          rx_irq
);
  AST_HOST_CLAIMS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) host_we |-> !pop); // R11
  AST_IRQ_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> $past(store)); // R4
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (adv && cur == IW'(RING - 1)) |=> cur == '0); // R10
  AST_RING_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cur <= IW'(RING - 1)); // R10
  AST_HELD_BYTES: assert property (@(posedge clk) disable iff (!rst_n) rel <= used); // R2
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) dropping |-> !store); // R8
  AST_MISS_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n) miss |=> $stable(cur)); // R9
endmodule

bind rxla_ctrl rxla_ctrl_chk #(.RING(RING), .IW(IW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .pop(go), .store(store),
  .miss(miss), .adv(close), .cur(cur), .rel(rel), .used(used),
  .dropping(dropping), .rx_irq(rx_irq)
);

// File: tb/tb_rxla_ctrl.sv
`timescale 1ns/1ps
module tb_rxla_ctrl;
  localparam int RING = 4, THRESH = 16, AW = 16, LW = 8, IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, early_irq_en = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic host_we = 1'b0, host_wown = 1'b0, host_wstp = 1'b0;
  logic [IW-1:0] host_widx = '0, host_ridx = '0;
  logic [AW-1:0] host_wbase = '0, host_rbase, mem_addr;
  logic [LW-1:0] host_wlen = '0, host_rlen, host_rcnt;
  logic [3:0] host_rflags;
  logic mem_we, rx_irq, buf_err;
  logic [7:0] mem_data;

  rxla_ctrl #(.RING(RING), .THRESH(THRESH), .AW(AW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .early_irq_en(early_irq_en),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .host_we(host_we), .host_widx(host_widx), .host_wbase(host_wbase),
    .host_wlen(host_wlen), .host_wown(host_wown), .host_wstp(host_wstp),
    .host_ridx(host_ridx), .host_rbase(host_rbase), .host_rlen(host_rlen),
    .host_rcnt(host_rcnt), .host_rflags(host_rflags),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .rx_irq(rx_irq), .buf_err(buf_err)
  );

  int total = 0, bad = 0, irq_n = 0, err_n = 0, wr_n = 0;
  logic [AW-1:0] exp_a [$];
  logic [7:0]    exp_d [$];
  logic [AW-1:0] ea;
  logic [7:0]    ed;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_irq) irq_n++;
      if (buf_err) err_n++;
      if (mem_we) begin
        wr_n++;
        if (exp_a.size() == 0) chk(1'b0, "R3", "unexpected write addr", int'(mem_addr), 0);
        else begin
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(mem_addr == ea, "R3", "write addr", int'(mem_addr), int'(ea));
          chk(mem_data == ed, "R3", "write data", int'(mem_data), int'(ed));
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_counts();
    irq_n = 0; err_n = 0; wr_n = 0;
  endtask

  task automatic expect_buf(input int base, input int seed, input int n);
    for (int k = 0; k < n; k++) begin
      exp_a.push_back(AW'(base + k));
      exp_d.push_back(8'(seed + k));
    end
  endtask

  task automatic send_rng(input int n, input int lo, input int hi, input int seed);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(seed + i);
      in_sof = (i == 0); in_eof = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic host_wr(input int idx, input int base, input int len, input bit own, input bit stp);
    @(negedge clk);
    host_we = 1'b1; host_widx = IW'(idx); host_wbase = AW'(base);
    host_wlen = LW'(len); host_wown = own; host_wstp = stp;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic chk_desc(input int idx, input int flags, input int cnt, input string req);
    host_ridx = IW'(idx);
    #1;
    chk(host_rflags == 4'(flags), req, $sformatf("desc%0d flags", idx), int'(host_rflags), flags);
    chk(host_rcnt == LW'(cnt), req, $sformatf("desc%0d count", idx), int'(host_rcnt), cnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(!mem_we && !rx_irq && !buf_err, "R1", "outputs in reset", {mem_we, rx_irq, buf_err}, 0);
    rst_n = 1'b1;
    idle(2);
    for (int i = 0; i < RING; i++) chk_desc(i, 0, 0, "R1");
    chk(!mem_we && !rx_irq && !buf_err, "R1", "outputs after reset", {mem_we, rx_irq, buf_err}, 0);

    // short frame released by its end marker (R2, R4, R12)
    early_irq_en = 1'b1;
    host_wr(0, 'h100, 16, 1, 1);
    zero_counts();
    expect_buf('h100, 'h10, 5);
    send_rng(5, 0, 5, 'h10);
    idle(12);
    chk(wr_n == 5, "R2", "short frame writes", wr_n, 5);
    chk(irq_n == 1, "R4", "end irq", irq_n, 1);
    chk_desc(0, 'b0110, 5, "R4");

    // three-buffer frame, third granted on early irq (R2, R5, R6)
    host_wr(1, 'h200, 16, 1, 1);
    host_wr(2, 'h300, 16, 1, 0);
    host_wr(3, 'h400, 32, 0, 0);
    zero_counts();
    expect_buf('h200, 'h40, 16);
    expect_buf('h300, 'h50, 16);
    expect_buf('h400, 'h60, 8);
    send_rng(40, 0, 15, 'h40);
    idle(6);
    chk(wr_n == 0, "R2", "writes before threshold", wr_n, 0);
    fork
      send_rng(40, 15, 40, 'h40);
      begin
        do @(negedge clk); while (!rx_irq);
        host_wr(3, 'h400, 32, 1, 0);
      end
    join
    idle(30);
    chk(wr_n == 40, "R5", "multi-buffer writes", wr_n, 40);
    chk(irq_n == 2, "R6", "early plus end irq", irq_n, 2);
    chk(err_n == 0, "R5", "no buffer error", err_n, 0);
    chk_desc(1, 'b0010, 16, "R5");
    chk_desc(2, 'b0000, 16, "R5");
    chk_desc(3, 'b0100, 8, "R4");

    // early option off, ring wraps to descriptor 0 (R6, R10)
    early_irq_en = 1'b0;
    host_wr(0, 'h500, 8, 1, 1);
    host_wr(1, 'h600, 8, 1, 0);
    zero_counts();
    expect_buf('h500, 'h80, 8);
    expect_buf('h600, 'h88, 4);
    send_rng(12, 0, 12, 'h80);
    idle(20);
    chk(irq_n == 1, "R6", "no early irq when disabled", irq_n, 1);
    chk_desc(0, 'b0010, 8, "R10");
    chk_desc(1, 'b0100, 4, "R4");

    // look-ahead miss, never granted: last-chance fails (R7, R8)
    early_irq_en = 1'b1;
    host_wr(2, 'h700, 20, 1, 1);
    zero_counts();
    expect_buf('h700, 'hA0, 20);
    send_rng(30, 0, 18, 'hA0);
    chk(err_n == 0, "R7", "no error at look-ahead miss", err_n, 0);
    send_rng(30, 18, 30, 'hA0);
    idle(40);
    chk(err_n == 1, "R8", "buffer error pulses", err_n, 1);
    chk(irq_n == 1, "R8", "irq on error return", irq_n, 1);
    chk(wr_n == 20, "R8", "rest of frame dropped", wr_n, 20);
    chk_desc(2, 'b1010, 20, "R8");

    // look-ahead miss, granted before buffer full (R7)
    host_wr(3, 'h800, 20, 1, 1);
    zero_counts();
    expect_buf('h800, 'hC0, 20);
    expect_buf('h900, 'hD4, 10);
    send_rng(30, 0, 18, 'hC0);
    chk(err_n == 0, "R7", "no error after miss", err_n, 0);
    host_wr(0, 'h900, 32, 1, 0);
    send_rng(30, 18, 30, 'hC0);
    idle(40);
    chk(err_n == 0, "R7", "late grant honoured", err_n, 0);
    chk(irq_n == 2, "R7", "irq count", irq_n, 2);
    chk_desc(3, 'b0010, 20, "R7");
    chk_desc(0, 'b0100, 10, "R7");

    // frame while current descriptor not owned (R9)
    zero_counts();
    send_rng(6, 0, 6, 'hE0);
    idle(15);
    chk(wr_n == 0, "R9", "dropped frame writes", wr_n, 0);
    chk(err_n == 1, "R9", "miss buffer error", err_n, 1);
    chk(irq_n == 0, "R9", "no irq on miss", irq_n, 0);
    host_wr(1, 'hA00, 16, 1, 1);
    expect_buf('hA00, 'hF0, 4);
    send_rng(4, 0, 4, 'hF0);
    idle(15);
    chk_desc(1, 'b0110, 4, "R9");

    // host writes during draining (R11)
    host_wr(2, 'hB00, 16, 1, 1);
    zero_counts();
    expect_buf('hB00, 'h30, 10);
    fork
      send_rng(10, 0, 10, 'h30);
      begin
        idle(11);
        repeat (4) host_wr(3, 'hC00, 12, 1, 1);
      end
    join
    idle(20);
    chk(wr_n == 10, "R11", "writes with host stalls", wr_n, 10);
    chk_desc(2, 'b0110, 10, "R11");
    chk_desc(3, 'b0011, 0, "R11");
    chk(host_rbase == AW'('hC00), "R11", "base written", int'(host_rbase), 'hC00);
    chk(host_rlen == LW'(12), "R11", "length written", int'(host_rlen), 12);

    chk(exp_a.size() == 0, "R3", "expected writes left", exp_a.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule